// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather Walker

This block moves a linear stream of bytes between a local buffer port and system memory. Software places a table of region descriptors in memory, and each descriptor names one memory region by its start address and its byte size. The block walks the table in order and moves bytes region by region until the requested byte count is exhausted or the table runs out. It then reports how many bytes it actually moved. A direction input selects the transfer direction. In buffer-to-memory mode, bytes arriving on the source stream are written to memory. In memory-to-buffer mode, bytes read from memory are pushed out on the sink stream.

Each descriptor occupies 16 bytes. The word at byte offset 0 holds the region address. The word at byte offset 12 holds the size in its low 22 bits. The words at offsets 4 and 8 are never read. Memory is reached through a simple request/acknowledge port: a request is held until it is acknowledged, and read data is valid in the acknowledge cycle. Data moves one byte per memory access, on the low byte lane.

The controller is a state machine with these states:
- IDLE waits for `start`.
- GET_ADDR fetches the address word of a descriptor.
- GET_SIZE fetches the size word of a descriptor.
- BEAT_IN takes one byte in, either from memory or from the source stream.
- BEAT_OUT hands that byte on, either to the sink stream or to memory.
- DONE pulses `done` for one cycle.

The transitions are:
- IDLE to GET_ADDR when a walk is launched.
- IDLE to DONE when the start parameters are empty.
- GET_ADDR to GET_SIZE on acknowledge.
- GET_SIZE to BEAT_IN for a region with bytes.
- GET_SIZE to GET_ADDR when skipping an empty entry.
- GET_SIZE to DONE when an empty last entry is reached.
- BEAT_IN to BEAT_OUT once the byte is held.
- BEAT_OUT to BEAT_IN when the region continues.
- BEAT_OUT to GET_ADDR when moving to the next entry.
- BEAT_OUT to DONE when the length or the table is exhausted.
- DONE to IDLE always.

Top module: `prd_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `src_ready` and `snk_valid` are 0, and `moved` is 0.
- R2: Descriptor i is read at `tbl_base + 16*i`. Its address comes from the word at offset 0 and its size from bits [21:0] of the word at offset 12. Bits [31:22] of the size word are ignored, and the words at offsets 4 and 8 are never requested.
- R3: Each descriptor moves min(size, remaining length) bytes to or from consecutive ascending byte addresses, beginning at the descriptor's address.
- R4: The walk ends when the remaining length reaches 0 or every descriptor is consumed, whichever happens first. At `done`, `moved` equals the bytes moved, which may be fewer than `xfer_len`.
- R5: Descriptors are consumed strictly in table order, and stream bytes map to memory bytes in order with no gaps.
- R6: With `dir_to_buf`=0, each source-stream byte is written to memory (`mem_we`=1, data in `mem_wdata[7:0]`). With `dir_to_buf`=1, each memory byte read (`mem_rdata[7:0]`) is presented on `snk_data`. The block never asserts `src_ready` and `snk_valid` together.
- R7: A descriptor whose size field is 0 moves no bytes and is skipped.
- R8: A start with `xfer_len`=0 or `tbl_entries`=0 issues no memory request. `done` rises in the cycle after start, with `moved`=0.
- R9: `busy` is high from the cycle after an accepted start through the `done` cycle. `done` lasts exactly one cycle. A `start` while busy is ignored.
- R10: While `mem_req` is high and not acknowledged, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a walk (sampled in IDLE) |
| dir_to_buf | input | 1 | 1 = memory to sink stream, 0 = source stream to memory |
| xfer_len | input | LEN_W | Requested byte count |
| tbl_base | input | ADDR_W | Byte address of descriptor 0 |
| tbl_entries | input | CNT_W | Number of descriptors |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| moved | output | LEN_W | Bytes moved by the last walk |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | MEM_W | Write data (byte in low lane) |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | MEM_W | Read data |
| src_valid | input | 1 | Source stream byte available |
| src_data | input | BEAT_W | Source stream byte |
| src_ready | output | 1 | Block takes the source byte |
| snk_valid | output | 1 | Sink stream byte available |
| snk_data | output | BEAT_W | Sink stream byte |
| snk_ready | input | 1 | Sink accepts the byte |

## Verification
The bench targets the limit that ends a walk. In one case the length runs out in the middle of a descriptor; a design that clipped wrongly would spill bytes past the requested count. In another case the table runs out before the length; there a walker that ignores the entry count would fetch garbage descriptors and hang or overrun. Zero-size descriptors and empty start parameters are exercised because an off-by-one walker would move a stray byte, or underflow its counter and run away. Garbage in the high bits of the size word, the unused descriptor words, a stalling sink and source, and a start raised mid-walk all probe for misdecoded fields and for a walk corrupted by a restart.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_ADDR,
        ST_GET_SIZE,
        ST_BEAT_IN,
        ST_BEAT_OUT,
        ST_DONE
    } walk_state_t;

    localparam int ENTRY_STRIDE  = 16;
    localparam int SIZE_WORD_OFS = 12;

endpackage

// File: rtl/prd_chunk_clip.sv
module prd_chunk_clip #(
    parameter int SIZE_W = 22,
    parameter int LEN_W  = 24,
    parameter int MEM_W  = 32
) (
    input  logic [MEM_W-1:0] size_word,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] chunk,
    output logic             empty
);
    localparam int CMP_W = (SIZE_W > LEN_W) ? SIZE_W : LEN_W;

    logic [CMP_W-1:0] sz_x;
    logic [CMP_W-1:0] rem_x;
    logic [CMP_W-1:0] pick;

    always_comb begin
        // only the low SIZE_W bits carry the region size
        sz_x  = CMP_W'(size_word[SIZE_W-1:0]);
        rem_x = CMP_W'(remain);
        pick  = (sz_x < rem_x) ? sz_x : rem_x;
        chunk = pick[LEN_W-1:0];
        empty = (pick == '0);
    end
endmodule

// File: rtl/prd_beat_hold.sv
module prd_beat_hold #(
    parameter int BEAT_W = 8,
    parameter int MEM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              from_mem,
    input  logic [BEAT_W-1:0] src_data,
    input  logic [MEM_W-1:0]  mem_rdata,
    output logic [BEAT_W-1:0] beat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (load) begin
            beat <= from_mem ? mem_rdata[BEAT_W-1:0] : src_data;
        end
    end
endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24,
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 22,
    parameter int BEAT_W = 8,
    parameter int MEM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_to_buf,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [CNT_W-1:0]  tbl_entries,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  moved,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [MEM_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [MEM_W-1:0]  mem_rdata,
    input  logic              src_valid,
    input  logic [BEAT_W-1:0] src_data,
    output logic              src_ready,
    output logic              snk_valid,
    output logic [BEAT_W-1:0] snk_data,
    input  logic              snk_ready
);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(ENTRY_STRIDE);
    localparam logic [ADDR_W-1:0] SZ_OFS  = ADDR_W'(SIZE_WORD_OFS);
    localparam logic [LEN_W-1:0]  LEN_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    walk_state_t state, nxt;

    logic              dir_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  req_len_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [LEN_W-1:0]  moved_q;
    logic [ADDR_W-1:0] entry_ptr_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  ents_left_q;

    logic [LEN_W-1:0]  clip_chunk;
    logic              clip_empty;
    logic [BEAT_W-1:0] beat_q;
    logic              last_entry;
    logic              size_ack;
    logic              beat_take;
    logic              beat_fire;
    logic              entry_end;

    prd_chunk_clip #(.SIZE_W(SIZE_W), .LEN_W(LEN_W), .MEM_W(MEM_W)) u_clip (
        .size_word (mem_rdata),
        .remain    (remain_q),
        .chunk     (clip_chunk),
        .empty     (clip_empty)
    );

    prd_beat_hold #(.BEAT_W(BEAT_W), .MEM_W(MEM_W)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (beat_take),
        .from_mem  (dir_q),
        .src_data  (src_data),
        .mem_rdata (mem_rdata),
        .beat      (beat_q)
    );

    assign last_entry = (ents_left_q == CNT_ONE);
    assign size_ack   = (state == ST_GET_SIZE) && mem_ack;
    assign beat_take  = (state == ST_BEAT_IN) && (dir_q ? mem_ack : src_valid);
    assign beat_fire  = (state == ST_BEAT_OUT) && (dir_q ? snk_ready : mem_ack);
    assign entry_end  = (size_ack && clip_empty) || (beat_fire && chunk_q == LEN_ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start)
                    nxt = (xfer_len == '0 || tbl_entries == '0) ? ST_DONE : ST_GET_ADDR;
            end
            ST_GET_ADDR: begin
                if (mem_ack) nxt = ST_GET_SIZE;
            end
            ST_GET_SIZE: begin
                if (mem_ack) begin
                    if (clip_empty) nxt = last_entry ? ST_DONE : ST_GET_ADDR;
                    else            nxt = ST_BEAT_IN;
                end
            end
            ST_BEAT_IN: begin
                if (beat_take) nxt = ST_BEAT_OUT;
            end
            ST_BEAT_OUT: begin
                if (beat_fire) begin
                    if (remain_q == LEN_ONE)     nxt = ST_DONE;
                    else if (chunk_q == LEN_ONE) nxt = last_entry ? ST_DONE : ST_GET_ADDR;
                    else                         nxt = ST_BEAT_IN;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q       <= 1'b0;
            remain_q    <= '0;
            req_len_q   <= '0;
            chunk_q     <= '0;
            moved_q     <= '0;
            entry_ptr_q <= '0;
            cur_addr_q  <= '0;
            ents_left_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                dir_q       <= dir_to_buf;
                remain_q    <= xfer_len;
                req_len_q   <= xfer_len;
                moved_q     <= '0;
                entry_ptr_q <= tbl_base;
                ents_left_q <= tbl_entries;
            end
            if (state == ST_GET_ADDR && mem_ack)
                cur_addr_q <= mem_rdata[ADDR_W-1:0];
            if (size_ack)
                chunk_q <= clip_chunk;
            if (beat_fire) begin
                cur_addr_q <= cur_addr_q + ADDR_W'(1);
                chunk_q    <= chunk_q - LEN_ONE;
                remain_q   <= remain_q - LEN_ONE;
                moved_q    <= moved_q + LEN_ONE;
            end
            if (entry_end) begin
                ents_left_q <= ents_left_q - CNT_ONE;
                entry_ptr_q <= entry_ptr_q + STRIDE;
            end
        end
    end

    // write data lane: byte in the low lane, zero above
    logic [MEM_W-1:0] wdata_w;
    generate
        if (MEM_W > BEAT_W) begin : g_pad
            assign wdata_w = {{(MEM_W-BEAT_W){1'b0}}, beat_q};
        end else begin : g_flat
            assign wdata_w = beat_q[MEM_W-1:0];
        end
    endgenerate

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        src_ready = 1'b0;
        snk_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_GET_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = entry_ptr_q;
            end
            ST_GET_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = entry_ptr_q + SZ_OFS;
            end
            ST_BEAT_IN: begin
                if (dir_q) begin
                    mem_req  = 1'b1;
                    mem_addr = cur_addr_q;
                end else begin
                    src_ready = 1'b1;
                end
            end
            ST_BEAT_OUT: begin
                if (dir_q) begin
                    snk_valid = 1'b1;
                end else begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = cur_addr_q;
                    mem_wdata = wdata_w;
                end
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign moved    = moved_q;
    assign snk_data = beat_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4
    moved_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (moved <= req_len_q));

    // R6
    dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_ready && snk_valid));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(req_len_q));

    // R3
    moved_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (moved == $past(moved) || moved == $past(moved) + LEN_ONE));

    // R7
    no_empty_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT_IN) |-> (chunk_q != '0));
endmodule

// File: tb/test_prd_walker.sv
`timescale 1ns/1ps
module test_prd_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_to_buf = 1'b0;
    logic [23:0] xfer_len = '0;
    logic [31:0] tbl_base = '0;
    logic [15:0] tbl_entries = '0;
    logic        busy, done;
    logic [23:0] moved;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic        src_valid = 1'b0;
    logic [7:0]  src_data;
    logic        src_ready;
    logic        snk_valid;
    logic [7:0]  snk_data;
    logic        snk_ready = 1'b0;

    always #2.5 clk = ~clk;

    prd_walker i_prd_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_to_buf(dir_to_buf),
        .xfer_len(xfer_len), .tbl_base(tbl_base), .tbl_entries(tbl_entries),
        .busy(busy), .done(done), .moved(moved),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready)
    );

    // memory model: preset bytes, design writes go to a log
    logic [7:0]  mem [0:1023];
    logic [31:0] wlog_a [0:255];
    logic [7:0]  wlog_d [0:255];
    logic [7:0]  slog   [0:255];
    int wn = 0, sn = 0, src_idx = 0, reqn = 0, bad_fetch = 0, hold_bad = 0;
    logic prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    logic src_stall = 1'b0, snk_stall = 1'b0;

    assign mem_rdata = {mem[mem_addr[9:0]+10'd3], mem[mem_addr[9:0]+10'd2],
                        mem[mem_addr[9:0]+10'd1], mem[mem_addr[9:0]]};
    assign src_data  = 8'(src_idx * 7 + 3);

    always @(negedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        src_valid <= src_stall ? ~src_valid : 1'b1;
        snk_ready <= snk_stall ? ~snk_ready : 1'b1;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            reqn <= reqn + 1;
            if (mem_we) begin
                wlog_a[wn[7:0]] <= mem_addr;
                wlog_d[wn[7:0]] <= mem_wdata[7:0];
                wn <= wn + 1;
            end else if (mem_addr < 32'h100 && (mem_addr[3:2] == 2'd1 || mem_addr[3:2] == 2'd2)) begin
                bad_fetch <= bad_fetch + 1;
            end
        end
        if (src_valid && src_ready) src_idx <= src_idx + 1;
        if (snk_valid && snk_ready) begin
            slog[sn[7:0]] <= snk_data;
            sn <= sn + 1;
        end
        if (rst_n && prev_pend && (!mem_req || mem_addr != prev_addr)) hold_bad <= hold_bad + 1;
        prev_pend <= mem_req && !mem_ack;
        prev_addr <= mem_addr;
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
    endtask

    task automatic put_entry(input int base, input int i, input logic [31:0] a, input logic [31:0] szw);
        put32(base + 16*i,      a);
        put32(base + 16*i + 4,  32'hDEAD_BEEF);
        put32(base + 16*i + 8,  32'h0BAD_F00D);
        put32(base + 16*i + 12, szw);
    endtask

    // launch a walk; optional restart poke at loop step poke (negative = none)
    task automatic run_walk(input logic d, input int len, input int base, input int cnt,
                            input int poke, output int got_moved, output int steps);
        @(negedge clk);
        start = 1'b1; dir_to_buf = d; xfer_len = 24'(len);
        tbl_base = 32'(base); tbl_entries = 16'(cnt);
        @(negedge clk);
        start = 1'b0;
        xfer_len = 24'h0000_55; tbl_base = 32'h3F0; tbl_entries = 16'd9; dir_to_buf = ~d;
        chk("R9 busy after start", 32'(busy), 32'd1);
        steps = 0;
        while (!done && steps < 3000) begin
            @(negedge clk);
            steps++;
            start = (steps == poke);
        end
        start = 1'b0;
        chk("R9 done reached", 32'(done), 32'd1);
        got_moved = int'(moved);
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 32'd0);
        chk("R9 idle after done", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 src_ready", 32'(src_ready), 0);
        chk("R1 snk_valid", 32'(snk_valid), 0);
        chk("R1 moved", 32'(moved), 0);
    endtask

    task automatic t_write_basic();
        int w0, s0, mv, st, k;
        int ea [12];
        put_entry(0, 0, 32'h200, 32'hFFC0_0004);
        put_entry(0, 1, 32'h240, 32'h0000_0005);
        put_entry(0, 2, 32'h280, 32'h8000_0003);
        for (int i = 0; i < 4; i++) ea[i] = 'h200 + i;
        for (int i = 0; i < 5; i++) ea[4+i] = 'h240 + i;
        for (int i = 0; i < 3; i++) ea[9+i] = 'h280 + i;
        w0 = wn; s0 = src_idx;
        src_stall = 1'b1;
        run_walk(1'b0, 12, 0, 3, -1, mv, st);
        src_stall = 1'b0;
        chk("R4 moved full", 32'(mv), 32'd12);
        chk("R3 write count", 32'(wn - w0), 32'd12);
        for (k = 0; k < 12; k++) begin
            chk("R5 R3 write addr", wlog_a[(w0+k) % 256], 32'(ea[k]));
            chk("R6 write data", 32'(wlog_d[(w0+k) % 256]), 32'(8'((s0 + k) * 7 + 3)));
        end
        chk("R2 unused words not fetched", 32'(bad_fetch), 32'd0);
    endtask

    task automatic t_len_short();
        int w0, mv, st;
        put_entry('h40, 0, 32'h300, 32'd4);
        put_entry('h40, 1, 32'h340, 32'd10);
        w0 = wn;
        run_walk(1'b0, 7, 'h40, 2, -1, mv, st);
        chk("R4 moved clipped by length", 32'(mv), 32'd7);
        chk("R3 write count clipped", 32'(wn - w0), 32'd7);
        chk("R3 second region start", wlog_a[(w0+4) % 256], 32'h340);
        chk("R3 last byte", wlog_a[(w0+6) % 256], 32'h342);
    endtask

    task automatic t_entries_short();
        int w0, mv, st;
        put_entry('h80, 0, 32'h380, 32'd3);
        put_entry('h80, 1, 32'h3A0, 32'd4);
        put_entry('h80, 2, 32'h3C0, 32'd8);
        w0 = wn;
        run_walk(1'b0, 20, 'h80, 2, -1, mv, st);
        chk("R4 moved less than requested", 32'(mv), 32'd7);
        chk("R4 no third entry", 32'(wn - w0), 32'd7);
        chk("R5 order second entry", wlog_a[(w0+3) % 256], 32'h3A0);
    endtask

    task automatic t_read();
        int w0, s0, q0, mv, st;
        logic [7:0] ex [8];
        for (int i = 0; i < 8; i++) mem['h200 + i] = 8'hA0 + 8'(i);
        for (int i = 0; i < 8; i++) mem['h260 + i] = 8'h50 + 8'(i);
        put_entry('hC0, 0, 32'h204, 32'd3);
        put_entry('hC0, 1, 32'h260, 32'hFFFF_FC05);
        ex = '{8'hA4, 8'hA5, 8'hA6, 8'h50, 8'h51, 8'h52, 8'h53, 8'h54};
        w0 = wn; s0 = src_idx; q0 = sn;
        snk_stall = 1'b1;
        run_walk(1'b1, 8, 'hC0, 2, -1, mv, st);
        snk_stall = 1'b0;
        chk("R4 read moved", 32'(mv), 32'd8);
        chk("R6 sink count", 32'(sn - q0), 32'd8);
        for (int k = 0; k < 8; k++)
            chk("R6 R5 sink byte", 32'(slog[(q0+k) % 256]), 32'(ex[k]));
        chk("R6 no memory writes", 32'(wn - w0), 32'd0);
        chk("R6 source untouched", 32'(src_idx - s0), 32'd0);
    endtask

    task automatic t_zero_entry();
        int w0, mv, st;
        put_entry(0, 0, 32'h2C0, 32'd2);
        put_entry(0, 1, 32'h2D0, 32'hFFC0_0000);
        put_entry(0, 2, 32'h2E0, 32'd3);
        w0 = wn;
        run_walk(1'b0, 5, 0, 3, -1, mv, st);
        chk("R7 moved", 32'(mv), 32'd5);
        chk("R7 writes", 32'(wn - w0), 32'd5);
        chk("R7 skip empty", wlog_a[(w0+2) % 256], 32'h2E0);
        chk("R7 last", wlog_a[(w0+4) % 256], 32'h2E2);
    endtask

    task automatic t_zero_start();
        int r0, mv, st;
        r0 = reqn;
        run_walk(1'b0, 0, 0, 3, -1, mv, st);
        chk("R8 zero length moved", 32'(mv), 0);
        chk("R8 zero length immediate", 32'(st), 0);
        run_walk(1'b1, 5, 0, 0, -1, mv, st);
        chk("R8 zero entries moved", 32'(mv), 0);
        chk("R8 zero entries immediate", 32'(st), 0);
        chk("R8 no memory request", 32'(reqn - r0), 0);
    endtask

    task automatic t_busy_start();
        int w0, mv, st;
        w0 = wn;
        run_walk(1'b0, 7, 'h40, 2, 3, mv, st);
        chk("R9 restart ignored moved", 32'(mv), 32'd7);
        chk("R9 restart ignored writes", 32'(wn - w0), 32'd7);
        chk("R9 restart ignored first addr", wlog_a[w0 % 256], 32'h300);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_basic();
        t_len_short();
        t_entries_short();
        t_read();
        t_zero_entry();
        t_zero_start();
        t_busy_start();
        repeat (4) @(negedge clk);
        chk("R10 request held until ack", 32'(hold_bad), 0);
        chk("R2 unused words never fetched", 32'(bad_fetch), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
        $finish;
    end
endmodule